// File: doc/BRIEF.md
# Shift-and-Add Track Parameter Fitter

This block turns seven hit coordinates of one track into three fitted parameters: an intercept, a slope and a curvature. Each parameter is a weighted sum of the seven hits, and the weights are fixed at build time. No multiplier is used. Each weight is the sum of two signed power-of-two terms, so one weighted hit costs two shift-and-add (or shift-and-subtract) steps. The block takes those steps in the two clock cycles that each hit is given.

Usage is simple. A `start` pulse clears the three running sums and the hit counter. The hits then arrive one per accepted `hit_valid`, at least two cycles apart. When the seventh hit has been folded in, the three sums are copied into held output registers and `done` pulses for one cycle. The weights come from the packed parameter `COEF`.

Top module: `trk_fit_shiftadd`

## Requirements
- R1: While reset is asserted and just after it is released, `done` is 0 and all three result outputs are 0.
- R2: Each weight term is 2+SHW bits wide, laid out as {zero, neg, shift}. If zero is 1, the term is worth 0. Otherwise it is worth +2^shift, or -2^shift when neg is 1. A weight is the sum of term 0 and term 1. Output p is selected by p = 0 for the intercept, 1 for the slope and 2 for the curvature. Hit k counts from 0. Term t of hit k for output p starts at bit ((p*NHIT+k)*2+t)*(2+SHW) of `COEF`.
- R3: After a complete track, each output equals the exact sum over k of weight(p,k) times the signed hit k. There is no overflow for any hit values inside the YW-bit signed range.
- R4: A hit is taken on a rising edge when `hit_valid` is 1, the previous edge did not take a hit, and fewer than NHIT hits have been taken since the last start or reset. A `hit_valid` in the cycle right after a taken hit has no effect.
- R5: Once NHIT hits have been taken, further hits are ignored until `start`. No `done` follows them and the outputs stay unchanged.
- R6: `done` is high for exactly one cycle. It is set on the second rising edge after the edge that takes the last hit, and the outputs update on that same edge. At all other times the outputs hold their value.
- R7: `start` clears the running sums and the hit count. A `hit_valid` in the same cycle is ignored, the held outputs are kept, and `done` is 0 after the start edge.
- R8: Idle cycles between hits do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a new track: clears the sums and the hit count |
| hit_valid | input | 1 | A hit coordinate is present on `hit_y` |
| hit_y | input | YW | Signed hit coordinate |
| fit_icpt | output | AW | Held intercept result, signed |
| fit_slope | output | AW | Held slope result, signed |
| fit_curv | output | AW | Held curvature result, signed |
| done | output | 1 | One-cycle pulse when new results are loaded |

## Verification
The assertions assume that `start` is never raised while a finished result is waiting to be loaded. This matters for the claim that the outputs move only together with `done`. The bench never issues `start` inside the two cycles that follow the last hit. The bench drives `hit_valid` in the ignored second cycle of a hit, during `start`, and after the seventh hit. This shows that the acceptance rule alone decides what enters the sums. The exact-sum check relies on hits staying inside the YW-bit signed range, and the sweep covers that whole range, including both extremes on every hit position.

// File: rtl/trk_fit_shiftadd.sv
module trk_fit_shiftadd #(
  parameter int YW   = 12,
  parameter int SHW  = 3,
  parameter int NHIT = 7,
  parameter int TW   = SHW + 2,
  parameter int AW   = YW + (1 << SHW) + 3,
  parameter logic [3*NHIT*2*TW-1:0] COEF =
    {(3*NHIT){ {1'b0, 1'b0, SHW'(1)}, {1'b1, 1'b0, SHW'(0)} }}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 hit_valid,
  input  logic signed [YW-1:0] hit_y,
  output logic signed [AW-1:0] fit_icpt,
  output logic signed [AW-1:0] fit_slope,
  output logic signed [AW-1:0] fit_curv,
  output logic                 done
);
  localparam int CW = $clog2(NHIT + 1);

  logic [CW-1:0]         cnt;
  logic                  ph, fin_q;
  logic signed [YW-1:0]  y_q;

  wire                   room   = cnt < CW'(NHIT);
  wire                   accept = hit_valid & ~ph & room;
  wire                   step   = accept | ph;
  wire [CW-1:0]          idx    = room ? cnt : '0;
  wire signed [YW-1:0]   y_op   = ph ? y_q : hit_y;
  wire signed [AW-1:0]   y_ext  = {{(AW-YW){y_op[YW-1]}}, y_op};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; ph <= 1'b0; fin_q <= 1'b0; done <= 1'b0; y_q <= '0;
    end else if (start) begin
      cnt <= '0; ph <= 1'b0; fin_q <= 1'b0; done <= 1'b0;
    end else begin
      done  <= fin_q;
      fin_q <= ph && (cnt == CW'(NHIT - 1));
      if (accept) begin
        ph  <= 1'b1;
        y_q <= hit_y;
      end else if (ph) begin
        ph  <= 1'b0;
        cnt <= cnt + 1'b1;
      end
    end
  end

  for (genvar p = 0; p < 3; p++) begin : g_par
    int                  base;
    logic [TW-1:0]       tm;
    logic signed [AW-1:0] mag, term, acc, res;

    always_comb begin
      base = ((p * NHIT + int'(idx)) * 2 + int'(ph)) * TW;
      tm   = COEF[base +: TW];
      mag  = y_ext <<< tm[SHW-1:0];
      term = tm[TW-1] ? '0 : (tm[TW-2] ? -mag : mag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc <= '0; res <= '0;
      end else if (start) begin
        acc <= '0;
      end else begin
        if (step)  acc <= acc + term;
        if (fin_q) res <= acc;
      end
    end
  end

  assign fit_icpt  = g_par[0].res;
  assign fit_slope = g_par[1].res;
  assign fit_curv  = g_par[2].res;
endmodule

// File: rtl/trk_fit_chk.sv
module trk_fit_chk #(
  parameter int CW   = 3,
  parameter int NHIT = 7,
  parameter int AW   = 23
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          ph,
  input logic [CW-1:0] cnt,
  input logic [AW-1:0] fit_icpt,
  input logic [AW-1:0] fit_slope,
  input logic [AW-1:0] fit_curv
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(fit_icpt) && $stable(fit_slope) && $stable(fit_curv))); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) done |-> cnt == CW'(NHIT)); // R6
  AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n) start |=> !done); // R7
  AST_TWO_CYCLE_HIT: assert property (@(posedge clk) disable iff (!rst_n) ph |=> !ph); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(NHIT)); // R5
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(NHIT) && !start) |=> cnt == CW'(NHIT)); // R5
endmodule

bind trk_fit_shiftadd trk_fit_chk #(.CW(CW), .NHIT(NHIT), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .ph(ph), .cnt(cnt),
  .fit_icpt(fit_icpt), .fit_slope(fit_slope), .fit_curv(fit_curv)
);

// File: tb/tb_trk_fit_shiftadd.sv
module tb_trk_fit_shiftadd;
  localparam int YW = 4, SHW = 3, NHIT = 7, TW = SHW + 2;
  localparam int AW = YW + (1 << SHW) + 3;
  localparam int CFW = 3 * NHIT * 2 * TW;

  function automatic logic [CFW-1:0] mk_coef();
    logic [CFW-1:0] r = '0;
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < NHIT; k++)
        for (int t = 0; t < 2; t++) begin
          int b = ((p * NHIT + k) * 2 + t) * TW;
          r[b +: TW] = {((p * 7 + k * 3 + t) % 5 == 4), ((p + 2 * k + t) % 3 == 1),
                        SHW'((p * 3 + k * 2 + t * 5) % 8)};
        end
    return r;
  endfunction
  localparam logic [CFW-1:0] CF = mk_coef();

  logic clk = 0, rst_n = 0, start = 0, hit_valid = 0;
  logic signed [YW-1:0] hit_y = '0;
  logic signed [AW-1:0] fit_icpt, fit_slope, fit_curv;
  logic done;

  trk_fit_shiftadd #(.YW(YW), .SHW(SHW), .NHIT(NHIT), .COEF(CF)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .hit_valid(hit_valid), .hit_y(hit_y),
    .fit_icpt(fit_icpt), .fit_slope(fit_slope), .fit_curv(fit_curv), .done(done));

  always #10 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int ty[NHIT];
  int ex[3];
  bit ended = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  function automatic int term_val(int p, int k, int t);
    logic [TW-1:0] tm = CF[((p * NHIT + k) * 2 + t) * TW +: TW];
    if (tm[TW-1]) return 0;
    return tm[TW-2] ? -(1 << tm[SHW-1:0]) : (1 << tm[SHW-1:0]);
  endfunction

  function automatic int outv(int p);
    return p == 0 ? int'(fit_icpt) : (p == 1 ? int'(fit_slope) : int'(fit_curv));
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic calc_exp();
    for (int p = 0; p < 3; p++) begin
      ex[p] = 0;
      for (int k = 0; k < NHIT; k++) ex[p] += (term_val(p, k, 0) + term_val(p, k, 1)) * ty[k];
    end
  endtask

  task automatic pulse_start(bit with_hit);
    start = 1; hit_valid = with_hit; hit_y = 4'sd5;
    @(negedge clk);
    start = 0; hit_valid = 0;
  endtask

  task automatic feed(int n, int gap, bit decoy);
    for (int k = 0; k < n; k++) begin
      hit_valid = 1; hit_y = YW'(ty[k]);
      @(negedge clk);
      hit_valid = decoy; hit_y = 4'sd7;
      @(negedge clk);
      hit_valid = 0;
      if (k != n - 1) repeat (gap) @(negedge clk);
    end
  endtask

  task automatic run_track(int gap, bit decoy, string req);
    feed(NHIT, gap, decoy);
    calc_exp();
    chk({req, " R6 done not early"}, int'(done), 0);
    @(negedge clk);
    chk("R6 done on second edge", int'(done), 1);
    for (int p = 0; p < 3; p++) chk({req, " R3 result"}, outv(p), ex[p]);
    @(negedge clk);
    chk("R6 done one cycle", int'(done), 0);
    for (int p = 0; p < 3; p++) chk("R6 result held", outv(p), ex[p]);
  endtask

  task automatic rnd_track();
    for (int k = 0; k < NHIT; k++) begin
      lfsr = lfsr * 32'd1103515245 + 32'd12345;
      ty[k] = int'(lfsr[19:16]) - 8;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    for (int p = 0; p < 3; p++) chk("R1 result in reset", outv(p), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    for (int p = 0; p < 3; p++) chk("R1 result after reset", outv(p), 0);

    // R3 R2: every hit value on all positions
    for (int v = -8; v < 8; v++) begin
      for (int k = 0; k < NHIT; k++) ty[k] = v;
      pulse_start(0);
      run_track(0, 1, "R2 uniform");
    end
    // R3: extremes on a single position each
    for (int k = 0; k < NHIT; k++)
      for (int s = 0; s < 2; s++) begin
        for (int j = 0; j < NHIT; j++) ty[j] = 0;
        ty[k] = s ? 7 : -8;
        pulse_start(0);
        run_track(0, 1, "R3 single");
      end
    // R3 R4: pseudo-random tracks with decoys in ignored cycles
    for (int i = 0; i < 20; i++) begin
      rnd_track();
      pulse_start(0);
      run_track(0, 1, "R4 random");
    end
    // R8: idle gaps between hits
    for (int g = 1; g < 4; g++) begin
      rnd_track();
      pulse_start(0);
      run_track(g, 0, "R8 gaps");
    end
    // R5: extra hits after the seventh are ignored
    begin
      int keep[3];
      for (int p = 0; p < 3; p++) keep[p] = ex[p];
      for (int k = 0; k < NHIT; k++) ty[k] = -8;
      feed(NHIT, 0, 1);
      for (int c = 0; c < 4; c++) begin
        chk("R5 no done after extra hits", int'(done), 0);
        @(negedge clk);
      end
      for (int p = 0; p < 3; p++) chk("R5 result unchanged", outv(p), keep[p]);
      // R7: start mid-track with a hit in the start cycle
      pulse_start(1);
      chk("R7 no done after start", int'(done), 0);
      for (int p = 0; p < 3; p++) chk("R7 result kept", outv(p), keep[p]);
      rnd_track();
      feed(3, 0, 0);
      pulse_start(1);
      rnd_track();
      run_track(0, 0, "R7 restart");
    end

    ended = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule